// File: doc/BRIEF.md
# Slow-to-Fast Clock and Data Capture

This block lets logic on a fast clock follow, cycle by cycle, a slower peripheral whose clock is unrelated to it. The peripheral clock itself is carried across as a single bit. A two-flop synchronizer on the fast clock samples it. A small edge state machine then turns each synchronized rising edge into an enable that is exactly one fast cycle long. That enable loads a data word that was already registered on the slow clock, so the word is taken exactly once per slow cycle. The value crossing is never metastable, and it is held for a whole slow period.

The fast side receives four things. The first is the captured word. The second is a one-cycle strobe that is high in the cycle the new word appears. The third is a copy of the synchronized slow clock, delayed so that its rising edges fall in the same cycle as the word changes. Downstream logic may gate that copy without creating false edges. The fourth is a free-running count of slow rising edges, so that actions can be keyed to particular slow-cycle numbers.

The edge state machine has two states. In `EDGE_ARMED` the synchronized clock is low. In `EDGE_HELD_HIGH` it is high. The transition RISE goes from `EDGE_ARMED` to `EDGE_HELD_HIGH` when the synchronized level is high, and it emits the capture enable. The transition FALL goes back when the level is low. In every other case the state holds. Correct operation requires the slow clock to run at no more than a third of the fast clock, so that each slow phase lasts at least 1.5 fast periods.

Top module: `slow_clock_capture`

## Requirements
- R1: While `frst` is high, and on the first cycle after it, `cap_data`, `cap_strobe`, `sclk_aligned` and `scycle_count` are all zero.
- R2: Each rising edge of `sclk` yields exactly one `cap_strobe` pulse, one fast cycle wide, whatever the length of the slow high phase, for slow/fast ratios of 3 and above.
- R3: At each strobe, `cap_data` holds the value that `sdata_in` had at the matching `sclk` rising edge. Words arrive in order, with none skipped or repeated.
- R4: `cap_strobe` and the new `cap_data` appear on the third rising `fclk` edge after the `sclk` rising edge. This is 2 to 3 fast periods later, depending on phase.
- R5: `sclk_aligned` is the synchronized slow clock delayed one more fast cycle. It rises exactly in the cycles where `cap_strobe` is high.
- R6: `scycle_count` increases by one, modulo 2^COUNT_W, in each strobe cycle and holds in every other cycle.
- R7: While `sclk` does not rise, changes on `sdata_in` have no effect. No strobe occurs, and `cap_data` and `scycle_count` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| fclk | input | 1 | Fast clock |
| frst | input | 1 | Synchronous active-high reset, fast domain |
| sclk | input | 1 | Slow asynchronous peripheral clock |
| sdata_in | input | DATA_W | Data word, launched on `sclk` rising edge |
| cap_data | output | DATA_W | Word captured in the fast domain |
| cap_strobe | output | 1 | One-cycle pulse when a new word is present |
| sclk_aligned | output | 1 | Synchronized slow clock, aligned with `cap_data` changes |
| scycle_count | output | COUNT_W | Count of slow rising edges since reset |

## Verification
The hardest case to reach is the tightest timing margin at a 3:1 ratio. There, the capture edge falls just before the next slow edge replaces the launched word. Another hard case is a slow edge landing just after a fast edge, which pushes latency to its 3-period maximum. The stimulus walks a table of slow high/low phase lengths: ratios of 3, 4 and 7, plus lopsided duty cycles. Each run starts at a random offset, in 5-unit steps plus 1, against the fast clock. Every relative phase of the two clocks is therefore covered, while no edges ever coincide. Directed tests hold the slow clock low, and separately hold it high, while the data input changes.

// File: rtl/scc_pkg.sv
package scc_pkg;

    typedef enum logic {
        EDGE_ARMED     = 1'b0,
        EDGE_HELD_HIGH = 1'b1
    } edge_state_e;

endpackage

// File: rtl/scc_launch_reg.sv
// Slow-domain launch register: the word leaves the slow domain already
// registered, so the fast side only ever sees settled values.
module scc_launch_reg #(
    parameter int WIDTH = 8
) (
    input  logic             sclk,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    always_ff @(posedge sclk) begin
        q <= d;
    end

endmodule

// File: rtl/scc_bit_sync.sv
// Single-bit synchronizer chain on the receiving clock. Never widen.
module scc_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/scc_rise_fsm.sv
// Two-state edge tracker: emits a single-cycle enable on the RISE transition.
module scc_rise_fsm
    import scc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic level,
    output logic rise_pulse
);

    edge_state_e state, state_nxt;

    always_ff @(posedge clk) begin
        if (rst) state <= EDGE_ARMED;
        else     state <= state_nxt;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            EDGE_ARMED:     if (level)  state_nxt = EDGE_HELD_HIGH;  // RISE
            EDGE_HELD_HIGH: if (!level) state_nxt = EDGE_ARMED;      // FALL
            default:                    state_nxt = EDGE_ARMED;
        endcase
    end

    always_comb begin
        rise_pulse = 1'b0;
        unique case (state)
            EDGE_ARMED:     rise_pulse = level;
            EDGE_HELD_HIGH: rise_pulse = 1'b0;
            default:        rise_pulse = 1'b0;
        endcase
    end

endmodule

// File: rtl/scc_capture.sv
// Fast-domain capture stage: data load, strobe, aligned clock copy, counter.
module scc_capture #(
    parameter int DATA_W  = 8,
    parameter int COUNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               rise_pulse,
    input  logic               level,
    input  logic [DATA_W-1:0]  slow_word,
    output logic [DATA_W-1:0]  cap_data,
    output logic               cap_strobe,
    output logic               aligned,
    output logic [COUNT_W-1:0] count
);

    localparam logic [COUNT_W-1:0] CNT_ONE = COUNT_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_data   <= '0;
            cap_strobe <= 1'b0;
            aligned    <= 1'b0;
            count      <= '0;
        end else begin
            cap_strobe <= rise_pulse;
            aligned    <= level;
            if (rise_pulse) begin
                cap_data <= slow_word;
                count    <= count + CNT_ONE;
            end
        end
    end

endmodule

// File: rtl/slow_clock_capture.sv
module slow_clock_capture #(
    parameter int DATA_W      = 8,
    parameter int COUNT_W     = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic               fclk,
    input  logic               frst,
    input  logic               sclk,
    input  logic [DATA_W-1:0]  sdata_in,
    output logic [DATA_W-1:0]  cap_data,
    output logic               cap_strobe,
    output logic               sclk_aligned,
    output logic [COUNT_W-1:0] scycle_count
);

    logic [DATA_W-1:0] launched;
    logic              sclk_sync;
    logic              rise_en;

    scc_launch_reg #(.WIDTH(DATA_W)) u_launch (
        .sclk (sclk),
        .d    (sdata_in),
        .q    (launched)
    );

    scc_bit_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk (fclk),
        .rst (frst),
        .d   (sclk),
        .q   (sclk_sync)
    );

    scc_rise_fsm u_edge (
        .clk        (fclk),
        .rst        (frst),
        .level      (sclk_sync),
        .rise_pulse (rise_en)
    );

    scc_capture #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_cap (
        .clk        (fclk),
        .rst        (frst),
        .rise_pulse (rise_en),
        .level      (sclk_sync),
        .slow_word  (launched),
        .cap_data   (cap_data),
        .cap_strobe (cap_strobe),
        .aligned    (sclk_aligned),
        .count      (scycle_count)
    );

endmodule

// File: rtl/scc_checker.sv
module scc_checker #(
    parameter int DATA_W  = 8,
    parameter int COUNT_W = 16
) (
    input logic               fclk,
    input logic               frst,
    input logic [DATA_W-1:0]  cap_data,
    input logic               cap_strobe,
    input logic               sclk_aligned,
    input logic [COUNT_W-1:0] scycle_count
);

    logic past_ok;

    always_ff @(posedge fclk) begin
        if (frst) past_ok <= 1'b0;
        else      past_ok <= 1'b1;
    end

    AST_RESET_CLEARS: assert property (@(posedge fclk)
        $past(frst) |-> (cap_data == '0 && !cap_strobe && !sclk_aligned && scycle_count == '0)); // R1

    AST_STROBE_SINGLE: assert property (@(posedge fclk) disable iff (frst)
        cap_strobe |=> !cap_strobe); // R2

    AST_DATA_HOLDS: assert property (@(posedge fclk) disable iff (frst)
        (past_ok && !cap_strobe) |-> (cap_data == $past(cap_data))); // R7

    AST_ALIGN_RISE: assert property (@(posedge fclk) disable iff (frst)
        (past_ok && $rose(sclk_aligned)) |-> cap_strobe); // R5

    AST_STROBE_ALIGNED: assert property (@(posedge fclk) disable iff (frst)
        cap_strobe |-> sclk_aligned); // R5

    AST_COUNT_STEP: assert property (@(posedge fclk) disable iff (frst)
        (past_ok && cap_strobe) |-> (scycle_count == COUNT_W'($past(scycle_count) + 1'b1))); // R6

    AST_COUNT_HOLD: assert property (@(posedge fclk) disable iff (frst)
        (past_ok && !cap_strobe) |-> $stable(scycle_count)); // R6

endmodule

bind slow_clock_capture scc_checker #(.DATA_W(DATA_W), .COUNT_W(COUNT_W)) u_chk (
    .fclk         (fclk),
    .frst         (frst),
    .cap_data     (cap_data),
    .cap_strobe   (cap_strobe),
    .sclk_aligned (sclk_aligned),
    .scycle_count (scycle_count)
);

// File: tb/sim_slow_clock_capture.sv
module sim_slow_clock_capture;

    localparam int FCLK_PERIOD = 10;
    localparam int DW = 8;
    localparam int CW = 16;
    localparam logic [DW-1:0] STEP = 8'd37;
    // hi, lo, cycles, base phase (all phases stay at 1 mod 5 vs fclk edges)
    localparam int NRUNS = 6;
    localparam int RUN_TAB [NRUNS][4] = '{
        '{15, 15, 40, 1},
        '{20, 20, 30, 6},
        '{35, 35, 20, 11},
        '{55, 15, 20, 16},
        '{15, 45, 20, 21},
        '{15, 15, 40, 26}
    };

    logic          fclk = 1'b0;
    logic          frst;
    logic          sclk;
    logic [DW-1:0] sdata_in;
    logic [DW-1:0] cap_data;
    logic          cap_strobe;
    logic          sclk_aligned;
    logic [CW-1:0] scycle_count;

    slow_clock_capture #(.DATA_W(DW), .COUNT_W(CW), .SYNC_STAGES(2)) u0 (
        .fclk, .frst, .sclk, .sdata_in, .cap_data, .cap_strobe, .sclk_aligned, .scycle_count
    );

    always #(FCLK_PERIOD/2) fclk = ~fclk;

    // Bench-side state (written only by the main initial block)
    int            b_checks = 0;
    int            b_errs   = 0;
    bit            done     = 1'b0;
    bit            mon_en   = 1'b0;
    int            run_gen  = 0;
    logic [DW-1:0] run_base = '0;
    logic [CW-1:0] cnt_base = '0;
    int            rise_n   = 0;
    longint        rise_t [256];

    // Monitor-side state (written only by the monitor)
    int            m_checks = 0;
    int            m_errs   = 0;
    int            last_gen = 0;
    int            strobe_n = 0;
    logic [DW-1:0] exp_val  = '0;
    logic [CW-1:0] exp_cnt  = '0;
    bit            prev_al  = 1'b0;
    bit            prev_stb = 1'b0;

    task automatic bcheck(input bit ok, input string tag, input longint act, input longint exp);
        b_checks++;
        if (!ok) begin
            b_errs++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic mcheck(input bit ok, input string tag, input longint act, input longint exp);
        m_checks++;
        if (!ok) begin
            m_errs++;
            $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge fclk) begin
        if (run_gen != last_gen) begin
            last_gen = run_gen;
            exp_val  = run_base;
            exp_cnt  = cnt_base;
            strobe_n = 0;
        end
        if (mon_en && !frst && cap_strobe) begin
            longint lat;
            mcheck(cap_data == exp_val, "R3 data order", cap_data, exp_val);
            mcheck(!prev_stb, "R2 strobe width", prev_stb, 0);
            mcheck(sclk_aligned && !prev_al, "R5 aligned rise", {prev_al, sclk_aligned}, 1);
            lat = $time - rise_t[strobe_n & 255];
            mcheck(lat > 25 && lat <= 35, "R4 latency", lat, 30);
            mcheck(scycle_count == CW'(exp_cnt + 1'b1), "R6 count step", scycle_count, CW'(exp_cnt + 1'b1));
            exp_val  = exp_val + STEP;
            exp_cnt  = exp_cnt + 1'b1;
            strobe_n = strobe_n + 1;
        end
        prev_al  = sclk_aligned;
        prev_stb = cap_strobe;
    end

    task automatic new_run(input logic [DW-1:0] base);
        @(negedge fclk);
        sdata_in = base;
        run_base = base;
        cnt_base = scycle_count;
        rise_n   = 0;
        run_gen  = run_gen + 1;
        @(negedge fclk);
    endtask

    task automatic run_slow(input int hi, input int lo, input int ncyc, input int ph, input logic [DW-1:0] base);
        logic [DW-1:0] v;
        v = base;
        new_run(base);
        #(ph);
        for (int k = 0; k < ncyc; k++) begin
            sclk = 1'b1;
            rise_t[rise_n & 255] = $time;
            rise_n++;
            #(hi);
            v = v + STEP;
            sdata_in = v;
            sclk = 1'b0;
            #(lo);
        end
        #(FCLK_PERIOD * 6);
        bcheck(strobe_n == rise_n, "R2 one strobe per slow edge", strobe_n, rise_n);
    endtask

    task automatic check_zero(input string tag);
        bcheck(cap_data == '0,     tag, cap_data, 0);
        bcheck(cap_strobe == 1'b0, tag, cap_strobe, 0);
        bcheck(sclk_aligned == 1'b0, tag, sclk_aligned, 0);
        bcheck(scycle_count == '0, tag, scycle_count, 0);
    endtask

    initial begin
        #(FCLK_PERIOD * 200000);
        if (!done) begin
            $display("FAIL watchdog expired actual 0 expected 1");
            $display("CHECKS %0d ERRORS %0d", b_checks + m_checks + 1, b_errs + m_errs + 1);
            $finish;
        end
    end

    initial begin
        frst = 1'b1;
        sclk = 1'b0;
        sdata_in = '0;
        repeat (3) @(posedge fclk);
        @(negedge fclk);
        check_zero("R1 reset state");
        frst = 1'b0;
        mon_en = 1'b1;
        @(negedge fclk);
        check_zero("R1 first cycle after reset");

        // Table walk: ratios 3, 4, 7 and lopsided duty, random phase offsets
        for (int i = 0; i < NRUNS; i++) begin
            int ph;
            ph = RUN_TAB[i][3] + 5 * int'($urandom_range(0, 9));
            run_slow(RUN_TAB[i][0], RUN_TAB[i][1], RUN_TAB[i][2], ph, DW'(8'h11 * (i + 1)));
        end

        // R7: slow clock idle low, data input toggling
        begin
            logic [DW-1:0] held_d;
            logic [CW-1:0] held_c;
            int            s0;
            held_d = cap_data;
            held_c = scycle_count;
            s0 = strobe_n;
            for (int k = 0; k < 30; k++) begin
                @(negedge fclk);
                sdata_in = sdata_in ^ DW'(k * 7 + 3);
            end
            repeat (6) @(negedge fclk);
            bcheck(cap_data == held_d,     "R7 data held", cap_data, held_d);
            bcheck(scycle_count == held_c, "R7 count held", scycle_count, held_c);
            bcheck(strobe_n == s0,         "R7 no strobe", strobe_n, s0);
        end

        // R2/R3: long high phase while data input keeps changing
        new_run(8'hA5);
        #1;
        sclk = 1'b1;
        rise_t[0] = $time;
        for (int k = 0; k < 40; k++) begin
            @(negedge fclk);
            sdata_in = DW'(k * 13 + 1);
        end
        bcheck(strobe_n == 1,      "R2 single strobe in long high", strobe_n, 1);
        bcheck(cap_data == 8'hA5,  "R3 word from rising edge", cap_data, 8'hA5);
        bcheck(sclk_aligned == 1'b1, "R5 aligned follows high level", sclk_aligned, 1);
        sclk = 1'b0;
        repeat (6) @(negedge fclk);
        bcheck(sclk_aligned == 1'b0, "R5 aligned follows low level", sclk_aligned, 0);

        // R1: reset in mid-operation clears a non-zero state
        bcheck(scycle_count != '0, "R6 count advanced", scycle_count, 1);
        @(negedge fclk);
        frst = 1'b1;
        @(negedge fclk);
        check_zero("R1 mid-run reset");
        frst = 1'b0;

        // Counting restarts from zero after reset
        run_slow(25, 25, 12, 1, 8'h3C);
        bcheck(scycle_count == CW'(12), "R6 count after reset", scycle_count, 12);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", b_checks + m_checks, b_errs + m_errs);
        $finish;
    end

endmodule